// File: doc/BRIEF.md
# Per-Slave Bus Arbiter

This block decides which of several bus masters may drive one slave port of a multi-master system bus. Every cycle it looks at the masters' request lines and, whenever the slave is free or the current owner reaches a burst boundary, it picks a new owner with either a rotating (round-robin) scheme or a programmable fixed-priority scheme. One configuration bit selects the scheme.

When no master requests the slave, the grant can be parked: dropped entirely, left on the most recent arbitration winner, or moved to a configured master. A parked master that starts a transfer uses the grant it already holds, so it sees no arbitration delay. Any other master gets its grant one cycle after raising its request. Undefined-length bursts can be cut short: each master has a beat limit, and once the owner has moved that many beats in an open-ended burst, the arbiter re-arbitrates as if the burst had ended.

The grant is a registered one-hot vector together with the owner's binary index. Address decoding, the data multiplexer and protection checks belong to neighbouring logic.

Top module: `bus_slave_arbiter`

## Requirements
- R1: While and right after reset, `gnt_o` is all zero and `gnt_idx_o` is 0.
- R2: With `fixed_mode_i`=0, the new owner is the first requesting master found by counting upward, with wraparound, from the index after the last arbitration winner. The search starts at master 0 after reset.
- R3: With `fixed_mode_i`=1, the new owner is the requester with the largest priority field. Master i's field is `prio_i[i*PW +: PW]`. On a tie, the lowest index wins.
- R4: While the owner keeps requesting and no burst boundary occurs, the grant does not change, whatever other masters request.
- R5: A boundary occurs when `beat_i`=1 and the owner's `last_i` bit is 1, or when the owner stops requesting. At a boundary the arbiter re-arbitrates, and the new grant appears after the next clock edge.
- R6: When the owner's `incr_i` bit is 1, its 3-bit limit `lim_i[i*3 +: 3]` sets the number of beats after which a boundary is forced. The codes are: 0 = no limit, 1 = 1 beat, 2 = 4 beats, 3 = 8 beats, 4 to 7 = 16 beats.
- R7: With no request and `park_type_i`=0 (or 3), the grant drops to all zero.
- R8: With no request and `park_type_i`=1, the grant goes to the most recent arbitration winner. If no master has won since reset, the grant is all zero.
- R9: With no request and `park_type_i`=2, the grant goes to master `park_idx_i`, which must be below NM.
- R10: A master that is already granted can transfer in the same cycle in which it raises its request, and it keeps the grant. A master that is not granted receives the grant one cycle after requesting, provided the slave is free.
- R11: `gnt_o` has at most one bit set, and when a bit is set, its position equals `gnt_idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NM | Request line of each master |
| incr_i | input | NM | The master's current burst has undefined length |
| last_i | input | NM | The master's current beat is the last one of its burst |
| beat_i | input | 1 | The slave accepts a beat from the owner this cycle |
| fixed_mode_i | input | 1 | 0 = round-robin, 1 = fixed priority |
| prio_i | input | NM*PW | Per-master priority fields |
| lim_i | input | NM*3 | Per-master beat-limit codes |
| park_type_i | input | 2 | 0 = no parking, 1 = last winner, 2 = fixed master |
| park_idx_i | input | IW | Master used for fixed parking |
| gnt_o | output | NM | One-hot grant |
| gnt_idx_o | output | IW | Index of the granted master |

## Verification
The assertions check on every cycle that the grant is one-hot or empty, that the grant holds while an owner is mid-burst, that a boundary with pending requests always produces a grant, and that parking with no requests clears the grant or moves it to the configured master. The beat counter is also checked for saturation. The bench's scenarios are the only way to show which master wins a contest under rotation or priority (including tie-breaking and wraparound), that each limit code ends an open burst after exactly the stated number of beats, that the last-winner parking mode works, and that a requester which is not parked waits exactly one cycle. A long random sweep compares every cycle against an arithmetic model of the requirements.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LIM_W = 3;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    PARK_NONE = 2'd0,
    PARK_LAST = 2'd1,
    PARK_FIX  = 2'd2
  } park_e;

  // limit code -> beats; 0 means unlimited
  function automatic logic [CNT_W-1:0] lim_beats(input logic [LIM_W-1:0] code);
    case (code)
      3'd0:    return CNT_W'(0);
      3'd1:    return CNT_W'(1);
      3'd2:    return CNT_W'(4);
      3'd3:    return CNT_W'(8);
      default: return CNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NM = 4,
  parameter int IW = 2
) (
  input  logic [NM-1:0] req_i,
  input  logic [IW-1:0] start_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int k = 0; k < NM; k++) begin
      int j;
      j = (int'(start_i) + k) % NM;
      if (!found && req_i[j]) begin
        found = 1'b1;
        idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_fix_pick.sv
module arb_fix_pick #(
  parameter int NM = 4,
  parameter int IW = 2,
  parameter int PW = 4
) (
  input  logic [NM-1:0]    req_i,
  input  logic [NM*PW-1:0] prio_i,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    logic          found;
    logic [PW-1:0] best;
    found = 1'b0;
    best  = '0;
    idx_o = '0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < NM; i++) begin
      if (req_i[i] && (!found || prio_i[i*PW +: PW] > best)) begin
        found = 1'b1;
        best  = prio_i[i*PW +: PW];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_beat_cnt.sv
module arb_beat_cnt #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          incr_i,
  input  logic [CW-1:0] len_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = incr_i && (len_i != '0) && ((cnt_q + 1'b1) == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  // R6
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '1 || cnt_q == '0));
endmodule

// File: rtl/bus_slave_arbiter.sv
module bus_slave_arbiter
  import arb_pkg::*;
#(
  parameter int NM = 4,
  parameter int PW = 4,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NM-1:0]    req_i,
  input  logic [NM-1:0]    incr_i,
  input  logic [NM-1:0]    last_i,
  input  logic             beat_i,
  input  logic             fixed_mode_i,
  input  logic [NM*PW-1:0] prio_i,
  input  logic [NM*3-1:0]  lim_i,
  input  logic [1:0]       park_type_i,
  input  logic [IW-1:0]    park_idx_i,
  output logic [NM-1:0]    gnt_o,
  output logic [IW-1:0]    gnt_idx_o
);
  localparam int LW = LIM_W;
  localparam int CW = CNT_W;

  logic [IW-1:0] own_q, rr_q, rr_start, rr_win, fx_win, win;
  logic          vld_q, lvld_q;
  logic          act, fin, rearb, any_req, lim_hit;
  logic [LW-1:0] lim_code;
  logic [CW-1:0] lim_len;

  assign any_req  = |req_i;
  assign act      = vld_q && req_i[own_q];
  assign lim_code = lim_i[int'(own_q)*LW +: LW];
  assign lim_len  = lim_beats(lim_code);
  assign fin      = act && beat_i && (last_i[own_q] || lim_hit);
  assign rearb    = !act || fin;
  assign rr_start = (int'(rr_q) == NM-1) ? '0 : rr_q + 1'b1;
  assign win      = fixed_mode_i ? fx_win : rr_win;

  arb_rr_pick #(.NM(NM), .IW(IW)) u_rr (
    .req_i(req_i), .start_i(rr_start), .idx_o(rr_win)
  );

  arb_fix_pick #(.NM(NM), .IW(IW), .PW(PW)) u_fix (
    .req_i(req_i), .prio_i(prio_i), .idx_o(fx_win)
  );

  arb_beat_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rearb),
    .inc_i (act && beat_i),
    .incr_i(incr_i[own_q]),
    .len_i (lim_len),
    .hit_o (lim_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= '0;
      vld_q  <= 1'b0;
      rr_q   <= IW'(NM-1);
      lvld_q <= 1'b0;
    end else if (rearb) begin
      if (any_req) begin
        own_q  <= win;
        vld_q  <= 1'b1;
        rr_q   <= win;
        lvld_q <= 1'b1;
      end else begin
        case (park_e'(park_type_i))
          PARK_LAST: begin
            own_q <= rr_q;
            vld_q <= lvld_q;
          end
          PARK_FIX: begin
            own_q <= park_idx_i;
            vld_q <= 1'b1;
          end
          default: vld_q <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (vld_q) gnt_o[own_q] = 1'b1;
  end
  assign gnt_idx_o = vld_q ? own_q : '0;

  // R11
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R4
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !fin) |=> (gnt_o == $past(gnt_o)));

  // R5
  rearb_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && any_req) |=> (gnt_o != '0));

  // R7
  park_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearb && !any_req && park_type_i == 2'd0) |=> (gnt_o == '0));

  // R9
  park_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearb && !any_req && park_type_i == 2'd2)
      |=> (gnt_idx_o == $past(park_idx_i) && gnt_o != '0));
endmodule

// File: tb/bus_slave_arbiter_tb_top.sv
module bus_slave_arbiter_tb_top;
  localparam int NM = 4;
  localparam int PW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    req, incr, last;
  logic          beat, fixed;
  logic [15:0]   prio;
  logic [11:0]   lim;
  logic [1:0]    ptype, pidx;
  logic [3:0]    gnt_o;
  logic [1:0]    gnt_idx_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  bit m_vld, m_lvld;
  int m_own, m_rr, m_cnt;

  always #2 clk_i = ~clk_i;

  bus_slave_arbiter #(.NM(NM), .PW(PW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .incr_i(incr), .last_i(last),
    .beat_i(beat), .fixed_mode_i(fixed), .prio_i(prio), .lim_i(lim),
    .park_type_i(ptype), .park_idx_i(pidx), .gnt_o(gnt_o), .gnt_idx_o(gnt_idx_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int beats_of(input int code);
    if (code == 0) return 0;
    if (code == 1) return 1;
    if (code == 2) return 4;
    if (code == 3) return 8;
    return 16;
  endfunction

  function automatic int pick();
    int best;
    best = -1;
    if (fixed) begin
      for (int i = 0; i < NM; i++)
        if (req[i] && (best < 0 || prio[i*PW +: PW] > prio[best*PW +: PW])) best = i;
    end else begin
      for (int k = 1; k <= NM; k++) begin
        int j;
        j = (m_rr + k) % NM;
        if (best < 0 && req[j]) best = j;
      end
    end
    return best;
  endfunction

  task automatic tick();
    bit act, fin;
    int lb;
    act = m_vld && req[m_own];
    lb  = beats_of(int'(lim[m_own*3 +: 3]));
    fin = act && beat && (last[m_own] || (incr[m_own] && lb != 0 && m_cnt + 1 == lb));
    if (act && !fin) begin
      if (beat && m_cnt < 31) m_cnt++;
    end else begin
      m_cnt = 0;
      if (req != 0) begin
        m_own = pick(); m_vld = 1; m_rr = m_own; m_lvld = 1;
      end else if (ptype == 2'd1) begin
        m_own = m_rr; m_vld = m_lvld;
      end else if (ptype == 2'd2) begin
        m_own = int'(pidx); m_vld = 1;
      end else m_vld = 0;
    end
    @(posedge clk_i);
    #1;
  endtask

  task automatic cmp_model(input string tag);
    chk(tag, int'(gnt_o), m_vld ? (1 << m_own) : 0);
    chk(tag, int'(gnt_idx_o), m_vld ? m_own : 0);
    chk("R11 onehot", $countones(gnt_o) <= 1, 1);
    if (gnt_o != 0) chk("R11 index", int'(gnt_o), 1 << gnt_idx_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g, n, exp;
    req = 0; incr = 0; last = 0; beat = 0; fixed = 0;
    prio = 0; lim = 0; ptype = 0; pidx = 0;
    m_vld = 0; m_lvld = 0; m_own = 0; m_rr = NM-1; m_cnt = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset gnt", int'(gnt_o), 0);
    chk("R1 reset idx", int'(gnt_idx_o), 0);
    rst_ni = 1'b1;
    tick(); tick();
    chk("R7 no park", int'(gnt_o), 0);

    // round-robin rotation with last beats
    req = 4'hF;
    tick();
    chk("R2 first winner", int'(gnt_idx_o), 0);
    beat = 1; last = 4'hF;
    tick(); chk("R5 boundary moves", int'(gnt_idx_o), 1);
    tick(); chk("R2 rotate", int'(gnt_idx_o), 2);
    tick(); chk("R2 rotate", int'(gnt_idx_o), 3);
    tick(); chk("R2 wrap", int'(gnt_idx_o), 0);
    last = 0;
    for (int c = 0; c < 3; c++) begin
      tick(); chk("R4 hold mid burst", int'(gnt_o), 1);
    end

    // fixed priority: m0=1 m1=3 m2=3 m3=0
    fixed = 1; prio = {4'd0, 4'd3, 4'd3, 4'd1}; last = 4'hF;
    tick(); chk("R3 tie lowest", int'(gnt_idx_o), 1);
    tick(); chk("R3 re-win", int'(gnt_idx_o), 1);
    req = 4'b1101;
    tick(); chk("R3 owner dropped", int'(gnt_idx_o), 2);

    // limit codes
    fixed = 0; last = 0; incr = 4'hF; beat = 0;
    for (int code = 0; code < 8; code++) begin
      req = 0; ptype = 0;
      tick(); tick();
      lim = {4{3'(code)}};
      req = 4'b0110;
      tick();
      g = int'(gnt_idx_o);
      beat = 1; n = 0;
      for (int k = 0; k < 20; k++) begin
        tick(); n++;
        if (int'(gnt_idx_o) != g) break;
      end
      beat = 0;
      exp = (beats_of(code) == 0) ? 20 : beats_of(code);
      chk($sformatf("R6 code %0d beats", code), n, exp);
    end

    // parking
    req = 0; ptype = 1;
    tick();
    chk("R8 park last", int'(gnt_idx_o), m_rr);
    chk("R8 park last vld", int'(gnt_o != 0), 1);
    ptype = 2; pidx = 3;
    tick();
    chk("R9 park fixed", int'(gnt_o), 8);
    req = 4'b1000; beat = 1; incr = 0;
    tick(); chk("R10 parked keeps", int'(gnt_o), 8);
    tick(); chk("R10 parked keeps", int'(gnt_o), 8);
    req = 4'b0010; beat = 0;
    tick(); chk("R10 one cycle", int'(gnt_o), 2);
    req = 0;
    tick(); chk("R9 back to park", int'(gnt_idx_o), 3);

    // random sweep against model
    for (int c = 0; c < 4000; c++) begin
      if (c % 97 == 0) begin
        fixed = 1'($urandom);
        prio  = 16'($urandom);
        lim   = 12'($urandom);
        ptype = 2'($urandom);
        pidx  = 2'($urandom);
      end
      req  = 4'($urandom) & 4'($urandom | 32'h5);
      incr = 4'($urandom);
      last = 4'($urandom) & 4'($urandom);
      beat = 1'($urandom);
      tick();
      cmp_model(fixed ? "R3 model" : "R2 model");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule